// File: doc/BRIEF.md
# Johnson-Sequenced State Register Bank with Test Preload

This block is a bank of registered output cells that together hold the state of a small sequencer. The next-state logic reads the register outputs back and steps a twisted-ring (Johnson) code forward or backward, one position per clock while advance is asserted. With a state width of W bits, 2*W codes are legal. Every other code is treated as corrupt. One normal clock moves a corrupt code to the all-zero home state.

For test, a preload mode cuts the loop from the registers back to their own inputs. While the preload enable is high, each register takes the matching bit of a preload vector on the clock edge, so each bit can be set high or low on its own. The bench can then place the machine in any of the 2^W codes, including those it never reaches in service. After preload it lowers the enable and clocks the machine as usual to check where it goes from the forced state. The register outputs drive the state port directly.

Top module: `preload_fsm_bank`

## Requirements
- R1: While rst_i is high at a rising clock edge, state_o is all zeros after that edge. This reset wins over preload and over the next-state inputs.
- R2: When pl_en_i is high at a rising edge and rst_i is low, state_o equals pl_data_i after that edge. Each bit is set independently, and this holds for all 2^W codes.
- R3: During preload, adv_i and dir_i have no effect on the value loaded.
- R4: A legal code counts as a thermometer code (ones filling from bit 0 upward, all zeros and all ones included) or the complement of one. When the code is legal, pl_en_i is low, adv_i=1 and dir_i=0, the next state is {state[W-2:0], ~state[W-1]}.
- R5: When the code is legal, pl_en_i is low, adv_i=1 and dir_i=1, the next state is {~state[0], state[W-1:1]}.
- R6: When the code is legal, pl_en_i is low and adv_i=0, the state holds.
- R7: When the code is illegal and pl_en_i is low, the next state is all zeros, whatever adv_i and dir_i are.
- R8: Stepping wraps around. For W=4, forward from 1000 gives 0000, and reverse from 0000 gives 1000.
- R9: Once pl_en_i falls, feedback is restored. The first normal edge steps from the preloaded code (for W=4, preload 0011 followed by a forward step gives 0111).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | Advance the sequence by one code |
| dir_i | input | 1 | Step direction: 0 forward, 1 reverse |
| pl_en_i | input | 1 | Preload enable, breaks feedback |
| pl_data_i | input | STATE_W | Code forced into the registers during preload |
| state_o | output | STATE_W | Register outputs, shown directly |

## Verification
The bench forces each of the sixteen codes in turn and then applies one normal step. A design that let corrupt codes wander, or that sent them to the wrong home, fails at the illegal codes. A design that decoded legality too loosely, such as by counting bit transitions, fails on codes like 0010. The bench raises preload together with advance and with reset, which catches a design that gives the next-state logic priority over preload, or preload priority over reset. Wrap-around in both directions and the first step after preload are checked directly, because a design that stayed cut off from feedback, or that stepped from stale state, goes wrong exactly there.

// File: rtl/pl_fsm_pkg.sv
`timescale 1ns/1ps
package pl_fsm_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } step_dir_e;
endpackage

// File: rtl/fsm_code_check.sv
`timescale 1ns/1ps
// Classifies a state code as a legal twisted-ring code.
module fsm_code_check #(
  parameter int STATE_W = 4
) (
  input  logic [STATE_W-1:0] code_i,
  output logic               legal_o
);
  logic [STATE_W-1:0] inv_code;
  logic               thermo_pos;
  logic               thermo_neg;

  assign inv_code = ~code_i;

  // a thermometer code plus one is a power of two (or wraps to zero)
  always_comb begin
    thermo_pos = ((code_i   & (code_i   + 1'b1)) == '0);
    thermo_neg = ((inv_code & (inv_code + 1'b1)) == '0);
    legal_o    = thermo_pos | thermo_neg;
  end
endmodule

// File: rtl/fsm_next_logic.sv
`timescale 1ns/1ps
// Fixed example next-state function: Johnson stepping with corrupt-code recovery.
module fsm_next_logic
  import pl_fsm_pkg::*;
#(
  parameter int STATE_W = 4
) (
  input  logic [STATE_W-1:0] cur_i,
  input  logic               legal_i,
  input  logic               adv_i,
  input  step_dir_e          dir_i,
  output logic [STATE_W-1:0] nxt_o
);
  localparam logic [STATE_W-1:0] HOME_CODE = '0;

  always_comb begin
    if (!legal_i) begin
      nxt_o = HOME_CODE;
    end else if (!adv_i) begin
      nxt_o = cur_i;
    end else if (dir_i == DIR_UP) begin
      nxt_o = {cur_i[STATE_W-2:0], ~cur_i[STATE_W-1]};
    end else begin
      nxt_o = {~cur_i[0], cur_i[STATE_W-1:1]};
    end
  end
endmodule

// File: rtl/pl_macrocell.sv
`timescale 1ns/1ps
// One registered output cell; preload selects the forced bit instead of feedback.
module pl_macrocell (
  input  logic clk_i,
  input  logic rst_i,
  input  logic pl_en_i,
  input  logic pl_bit_i,
  input  logic nxt_bit_i,
  output logic q_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      q_o <= 1'b0;
    end else if (pl_en_i) begin
      q_o <= pl_bit_i;
    end else begin
      q_o <= nxt_bit_i;
    end
  end
endmodule

// File: rtl/preload_fsm_bank.sv
`timescale 1ns/1ps
module preload_fsm_bank
  import pl_fsm_pkg::*;
#(
  parameter int STATE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               adv_i,
  input  logic               dir_i,
  input  logic               pl_en_i,
  input  logic [STATE_W-1:0] pl_data_i,
  output logic [STATE_W-1:0] state_o
);
  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] next_state;
  logic               code_legal;
  step_dir_e          step_dir;

  assign step_dir = step_dir_e'(dir_i);

  fsm_code_check #(.STATE_W(STATE_W)) legal_u (
    .code_i  (state_q),
    .legal_o (code_legal)
  );

  fsm_next_logic #(.STATE_W(STATE_W)) next_u (
    .cur_i   (state_q),
    .legal_i (code_legal),
    .adv_i   (adv_i),
    .dir_i   (step_dir),
    .nxt_o   (next_state)
  );

  for (genvar b = 0; b < STATE_W; b++) begin : g_cell
    pl_macrocell cell_u (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .pl_en_i   (pl_en_i),
      .pl_bit_i  (pl_data_i[b]),
      .nxt_bit_i (next_state[b]),
      .q_o       (state_q[b])
    );
  end

  assign state_o = state_q;
endmodule

// File: rtl/preload_fsm_bank_chk.sv
`timescale 1ns/1ps
module preload_fsm_bank_chk #(
  parameter int STATE_W = 4
) (
  input logic               clk_i,
  input logic               rst_i,
  input logic               adv_i,
  input logic               dir_i,
  input logic               pl_en_i,
  input logic [STATE_W-1:0] pl_data_i,
  input logic [STATE_W-1:0] state_o
);
  // legality found by walking the whole ring from zero
  function automatic logic ring_member(input logic [STATE_W-1:0] c);
    logic [STATE_W-1:0] t;
    logic               hit;
    t   = '0;
    hit = 1'b0;
    for (int k = 0; k < 2*STATE_W; k++) begin
      if (c == t) hit = 1'b1;
      t = {t[STATE_W-2:0], ~t[STATE_W-1]};
    end
    return hit;
  endfunction

  logic cur_legal;
  assign cur_legal = ring_member(state_o);

  // R1
  reset_zero_chk: assert property (@(posedge clk_i)
    rst_i |=> state_o == '0);

  // R2 and R3
  preload_take_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    pl_en_i |=> state_o == $past(pl_data_i));

  // R4
  fwd_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!pl_en_i && adv_i && !dir_i && cur_legal)
      |=> state_o == {$past(state_o[STATE_W-2:0]), ~$past(state_o[STATE_W-1])});

  // R5
  rev_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!pl_en_i && adv_i && dir_i && cur_legal)
      |=> state_o == {~$past(state_o[0]), $past(state_o[STATE_W-1:1])});

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!pl_en_i && !adv_i && cur_legal) |=> $stable(state_o));

  // R7
  corrupt_home_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!pl_en_i && !cur_legal) |=> state_o == '0);
endmodule

bind preload_fsm_bank preload_fsm_bank_chk #(.STATE_W(STATE_W)) chk_i (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .adv_i     (adv_i),
  .dir_i     (dir_i),
  .pl_en_i   (pl_en_i),
  .pl_data_i (pl_data_i),
  .state_o   (state_o)
);

// File: tb/preload_fsm_bank_tb_top.sv
`timescale 1ns/1ps
module preload_fsm_bank_tb_top;
  localparam int W = 4;
  localparam int NVEC = 20;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         adv = 1'b0;
  logic         dir = 1'b0;
  logic         pl_en = 1'b0;
  logic [W-1:0] pl_data = '0;
  logic [W-1:0] state;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  preload_fsm_bank #(.STATE_W(W)) dut_i (
    .clk_i     (clk),
    .rst_i     (rst),
    .adv_i     (adv),
    .dir_i     (dir),
    .pl_en_i   (pl_en),
    .pl_data_i (pl_data),
    .state_o   (state)
  );

  // {pl_en, pl_data, adv, dir, expected, requirement}
  localparam logic [14:0] VECS [NVEC] = '{
    {1'b0, 4'h0, 1'b1, 1'b0, 4'b0001, 4'd4},  // R4
    {1'b0, 4'h0, 1'b1, 1'b0, 4'b0011, 4'd4},  // R4
    {1'b0, 4'h0, 1'b0, 1'b0, 4'b0011, 4'd6},  // R6
    {1'b0, 4'h0, 1'b1, 1'b1, 4'b0001, 4'd5},  // R5
    {1'b0, 4'h0, 1'b1, 1'b1, 4'b0000, 4'd5},  // R5
    {1'b0, 4'h0, 1'b1, 1'b1, 4'b1000, 4'd8},  // R8
    {1'b0, 4'h0, 1'b1, 1'b0, 4'b0000, 4'd8},  // R8
    {1'b1, 4'h5, 1'b1, 1'b0, 4'b0101, 4'd3},  // R3
    {1'b0, 4'h0, 1'b0, 1'b0, 4'b0000, 4'd7},  // R7
    {1'b1, 4'hA, 1'b0, 1'b0, 4'b1010, 4'd2},  // R2
    {1'b0, 4'h0, 1'b1, 1'b1, 4'b0000, 4'd7},  // R7
    {1'b1, 4'h3, 1'b1, 1'b0, 4'b0011, 4'd3},  // R3
    {1'b0, 4'h0, 1'b1, 1'b0, 4'b0111, 4'd9},  // R9
    {1'b1, 4'hF, 1'b0, 1'b1, 4'b1111, 4'd2},  // R2
    {1'b0, 4'h0, 1'b1, 1'b0, 4'b1110, 4'd4},  // R4
    {1'b0, 4'h0, 1'b1, 1'b0, 4'b1100, 4'd4},  // R4
    {1'b0, 4'h0, 1'b1, 1'b0, 4'b1000, 4'd4},  // R4
    {1'b0, 4'h0, 1'b1, 1'b0, 4'b0000, 4'd8},  // R8
    {1'b1, 4'h6, 1'b1, 1'b1, 4'b0110, 4'd2},  // R2
    {1'b0, 4'h0, 1'b0, 1'b0, 4'b0000, 4'd7}   // R7
  };

  // bench model: the legal set is listed explicitly
  function automatic logic legal_code(input logic [W-1:0] c);
    return (c == 4'b0000) || (c == 4'b0001) || (c == 4'b0011) || (c == 4'b0111) ||
           (c == 4'b1111) || (c == 4'b1110) || (c == 4'b1100) || (c == 4'b1000);
  endfunction

  function automatic logic [W-1:0] model_next(input logic [W-1:0] c, input logic a,
                                              input logic d);
    if (!legal_code(c)) return 4'b0000;
    if (!a) return c;
    if (!d) return {c[2:0], ~c[3]};
    return {~c[0], c[3:1]};
  endfunction

  task automatic check(input logic [W-1:0] exp, input int req, input string what);
    n_run++;
    if (state !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: got %b expected %b", req, what, state, exp);
    end
  endtask

  // drive at the falling edge, take one rising edge, sample at the next falling edge
  task automatic cycle(input logic r, input logic p, input logic [W-1:0] pd,
                       input logic a, input logic d);
    rst = r; pl_en = p; pl_data = pd; adv = a; dir = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    cycle(1'b1, 1'b0, '0, 1'b1, 1'b0);
    check(4'b0000, 1, "reset state");           // R1

    for (int i = 0; i < NVEC; i++) begin
      cycle(1'b0, VECS[i][14], VECS[i][13:10], VECS[i][9], VECS[i][8]);
      check(VECS[i][7:4], int'(VECS[i][3:0]), $sformatf("vector %0d", i));
    end

    // R1: reset beats a simultaneous preload
    cycle(1'b0, 1'b1, 4'b1011, 1'b0, 1'b0);
    cycle(1'b1, 1'b1, 4'b1111, 1'b1, 1'b0);
    check(4'b0000, 1, "reset over preload");

    // R2, R7, R9: force every code, then one normal step
    for (int c = 0; c < 16; c++) begin
      logic [W-1:0] code;
      logic         d;
      code = W'(c);
      d    = code[1];
      cycle(1'b0, 1'b1, code, 1'b1, d);
      check(code, 2, $sformatf("preload %b", code));
      cycle(1'b0, 1'b0, '0, 1'b1, d);
      check(model_next(code, 1'b1, d), legal_code(code) ? 9 : 7,
            $sformatf("step from %b dir %b", code, d));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule